// File: doc/BRIEF.md
# Glitchless Output Enable Router

This block gates eight clock outputs under three shared, active-low enable pins. A static link matrix decides which pins govern which outputs. One pin may control many outputs, and one output may follow several pins. When several linked pins disagree, a request to disable wins. Each output also has a static polarity-invert option and a parked state that applies while it is not clocking: driven low, driven high, or high-impedance. Any output can be powered down, which holds it off whatever the pins do.

The block runs on one fast system clock `clk` that oversamples the eight source clocks. Each source must stay at least two `clk` cycles in each phase. The enable pins are asynchronous. They pass through a two-stage synchronizer in the `clk` domain before any decision uses them. An output starts and stops only at a rising edge of its own source. It therefore never emits a shortened pulse: it starts on a leading edge and always finishes the cycle in progress before it parks. Each output is a data bit plus an output-enable bit, and a pad cell downstream drives or floats the pin from them.

Top module: `oe_router`

## Requirements
- R1: While `rst_n` is low, all `clkOut` and `clkOe` bits are 0.
- R2: Bit `linkMask[3*i+j]` links enable pin j to output i. A linked pin that is low permits output i to run, and a linked pin that is high asks it to stop. An output with no links is always permitted.
- R3: When an output is linked to several pins, it is permitted only if every linked pin is low. Any single high pin disables it.
- R4: While output i is clocking, `clkOe[i]` is 1 and `clkOut[i]` equals `srcClk[i]` as sampled two `clk` edges earlier, XOR `invert[i]`.
- R5: A permitted output that is parked starts clocking only at a rising edge of its source. Its first high phase therefore has full length.
- R6: When permission is withdrawn, the output keeps clocking until the next rising edge of its source. It parks there, so the last cycle completes in full.
- R7: The parked state is set by `parkMode[2*i+1:2*i]`. 00 drives 0 with `clkOe`=1, 01 drives 1 with `clkOe`=1, and 10 or 11 give high-impedance (`clkOe`=0, `clkOut`=0).
- R8: `invert[i]` affects only a clocking output. A parked output shows its parked value whatever `invert[i]` is, and 0 means non-inverted.
- R9: With `powerDown[i]` at 1, output i has `clkOut`=0 and `clkOe`=0 from the next `clk` edge on, whatever the pins are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcClk | input | 8 | Source clock per output |
| nOePin | input | 3 | Active-low enable pins, asynchronous |
| linkMask | input | 24 | Pin-to-output links, bit 3*i+j links pin j to output i |
| invert | input | 8 | Per-output polarity invert while clocking |
| parkMode | input | 16 | Two bits per output selecting the parked state |
| powerDown | input | 8 | Per-output permanent disable |
| clkOut | output | 8 | Output clock data |
| clkOe | output | 8 | Output driver enable |

## Verification
The bound checker watches every cycle and every output for four things. A clocking output must track its delayed source with the right polarity. An output may change level only when its delayed source changes, so it never glitches. A released driver must trace back to a high-impedance or powered-down setting. A powered-down output must stay quiet. Pin-to-output resolution and disable dominance, including the mix of linked and unlinked outputs, show only in the bench's table of pin patterns, because the checker does not see the synchronizer timing. Full-length first and last pulses around enable and disable also show only in the bench's recorded traces.

// File: rtl/oe_router_pkg.sv
package oe_router_pkg;
  parameter int OUT_COUNT = 8;
  parameter int PIN_COUNT = 3;
  parameter int PARK_W    = 2;

  typedef enum logic [PARK_W-1:0] {
    PARK_LOW  = 2'b00,
    PARK_HIGH = 2'b01,
    PARK_HIZ  = 2'b10,
    PARK_HIZ2 = 2'b11
  } park_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [OUT_COUNT-1:0] runNext;
    logic [OUT_COUNT-1:0] forceOff;
  } ctrl_strobe_t;
endpackage

// File: rtl/oe_router_dp.sv
module oe_router_dp
  import oe_router_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [OUT_COUNT-1:0]        srcClk,
  input  logic [OUT_COUNT-1:0]        invert,
  input  logic [OUT_COUNT*PARK_W-1:0] parkMode,
  input  ctrl_strobe_t                strobe,
  output logic [OUT_COUNT-1:0]        srcRise,
  output logic [OUT_COUNT-1:0]        clkOut,
  output logic [OUT_COUNT-1:0]        clkOe
);
  logic [OUT_COUNT-1:0] srcQ;
  logic [OUT_COUNT-1:0] srcPrev;
  logic [OUT_COUNT-1:0] nextData;
  logic [OUT_COUNT-1:0] nextOe;

  // reset to ones so no false rise appears right after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcQ    <= '1;
      srcPrev <= '1;
    end else begin
      srcQ    <= srcClk;
      srcPrev <= srcQ;
    end
  end

  assign srcRise = srcQ & ~srcPrev;

  generate
    for (genvar i = 0; i < OUT_COUNT; i++) begin : g_lane
      park_e mode;
      assign mode = park_e'(parkMode[i*PARK_W +: PARK_W]);

      assign nextData[i] = strobe.forceOff[i] ? 1'b0 :
                           strobe.runNext[i]  ? (srcQ[i] ^ invert[i]) :
                           (mode == PARK_HIGH);
      assign nextOe[i]   = strobe.forceOff[i] ? 1'b0 :
                           strobe.runNext[i]  ? 1'b1 :
                           ((mode == PARK_LOW) || (mode == PARK_HIGH));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkOut <= '0;
      clkOe  <= '0;
    end else begin
      clkOut <= nextData;
      clkOe  <= nextOe;
    end
  end
endmodule

// File: rtl/oe_router_ctrl.sv
module oe_router_ctrl
  import oe_router_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PIN_COUNT-1:0]           nOePin,
  input  logic [OUT_COUNT*PIN_COUNT-1:0] linkMask,
  input  logic [OUT_COUNT-1:0]           powerDown,
  input  logic [OUT_COUNT-1:0]           srcRise,
  output ctrl_strobe_t                   strobe
);
  logic [SYNC_STAGES-1:0][PIN_COUNT-1:0] syncQ;
  logic [PIN_COUNT-1:0] pinsHeld;
  logic [OUT_COUNT-1:0] running;
  logic [OUT_COUNT-1:0] wantOff;
  logic [OUT_COUNT-1:0] runNext;

  // pins reset to the disabling level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '1;
    end else begin
      syncQ[0] <= nOePin;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinsHeld = syncQ[SYNC_STAGES-1];

  generate
    for (genvar i = 0; i < OUT_COUNT; i++) begin : g_resolve
      // any linked pin that is high stops the output
      assign wantOff[i] = powerDown[i] |
                          (|(linkMask[i*PIN_COUNT +: PIN_COUNT] & pinsHeld));
      // decisions change only at a source rising edge
      assign runNext[i] = powerDown[i] ? 1'b0 :
                          srcRise[i]   ? ~wantOff[i] : running[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= '0;
    else        running <= runNext;
  end

  assign strobe.runNext  = runNext;
  assign strobe.forceOff = powerDown;
endmodule

// File: rtl/oe_router.sv
module oe_router
  import oe_router_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [OUT_COUNT-1:0]           srcClk,
  input  logic [PIN_COUNT-1:0]           nOePin,
  input  logic [OUT_COUNT*PIN_COUNT-1:0] linkMask,
  input  logic [OUT_COUNT-1:0]           invert,
  input  logic [OUT_COUNT*PARK_W-1:0]    parkMode,
  input  logic [OUT_COUNT-1:0]           powerDown,
  output logic [OUT_COUNT-1:0]           clkOut,
  output logic [OUT_COUNT-1:0]           clkOe
);
  ctrl_strobe_t         strobe;
  logic [OUT_COUNT-1:0] srcRise;

  oe_router_ctrl #(.SYNC_STAGES(2)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .nOePin    (nOePin),
    .linkMask  (linkMask),
    .powerDown (powerDown),
    .srcRise   (srcRise),
    .strobe    (strobe)
  );

  oe_router_dp i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .srcClk   (srcClk),
    .invert   (invert),
    .parkMode (parkMode),
    .strobe   (strobe),
    .srcRise  (srcRise),
    .clkOut   (clkOut),
    .clkOe    (clkOe)
  );
endmodule

// File: rtl/oe_router_chk.sv
module oe_router_chk
  import oe_router_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [OUT_COUNT-1:0]        srcClk,
  input logic [OUT_COUNT-1:0]        invert,
  input logic [OUT_COUNT*PARK_W-1:0] parkMode,
  input logic [OUT_COUNT-1:0]        powerDown,
  input logic [OUT_COUNT-1:0]        clkOut,
  input logic [OUT_COUNT-1:0]        clkOe
);
  localparam int CFG_W = 2*OUT_COUNT + OUT_COUNT*PARK_W;

  logic [OUT_COUNT-1:0] srcD1, srcD2;
  logic [CFG_W-1:0]     cfgQ1, cfgQ2;
  logic                 arm1, arm2;
  logic                 cfgSteady;

  always_ff @(posedge clk) begin
    srcD1 <= srcClk;
    srcD2 <= srcD1;
    cfgQ1 <= {invert, powerDown, parkMode};
    cfgQ2 <= cfgQ1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm1 <= 1'b0;
      arm2 <= 1'b0;
    end else begin
      arm1 <= 1'b1;
      arm2 <= arm1;
    end
  end

  assign cfgSteady = (cfgQ1 == cfgQ2);

  generate
    for (genvar i = 0; i < OUT_COUNT; i++) begin : g_prop
      // R4
      follow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2 && clkOe[i] && $past(parkMode[PARK_W*i+1]) && !$past(powerDown[i]))
        |-> (clkOut[i] == (srcD2[i] ^ $past(invert[i]))));
      // R5 R6
      no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2 && cfgSteady && (clkOut[i] != $past(clkOut[i])))
        |-> (srcD2[i] != $past(srcD2[i])));
      // R7
      oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2 && !clkOe[i])
        |-> ($past(parkMode[PARK_W*i+1]) || $past(powerDown[i])));
      // R9
      pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2 && $past(powerDown[i])) |-> (!clkOe[i] && !clkOut[i]));
    end
  endgenerate
endmodule

bind oe_router oe_router_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srcClk    (srcClk),
  .invert    (invert),
  .parkMode  (parkMode),
  .powerDown (powerDown),
  .clkOut    (clkOut),
  .clkOe     (clkOe)
);

// File: tb/test_oe_router.sv
module test_oe_router;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [23:0] LINKS = 24'h6B8B11;
  // {pins[42:40], powerDown[39:32], invert[31:24], parkMode[23:8], expected running[7:0]}
  localparam logic [42:0] VECS [NV] = '{
    {3'b000, 8'h00, 8'h00, 16'hE4E4, 8'hFF},
    {3'b111, 8'h00, 8'hFF, 16'h1B1B, 8'h10},
    {3'b001, 8'h00, 8'hA5, 16'hE4E4, 8'h56},
    {3'b100, 8'h00, 8'h0F, 16'h1B1B, 8'hD3},
    {3'b010, 8'h11, 8'h3C, 16'hE4E4, 8'h0C},
    {3'b000, 8'h80, 8'hF0, 16'h1B1B, 8'h7F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  srcClk = '0;
  logic [2:0]  nOePin = 3'b111;
  logic [23:0] linkMask = LINKS;
  logic [7:0]  invert = '0;
  logic [15:0] parkMode = '0;
  logic [7:0]  powerDown = '0;
  logic [7:0]  clkOut, clkOe;

  logic [7:0] hPrev = '0;
  logic [7:0] expSrc = '0;
  int cnt [8];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oe_router i_oe_router (
    .clk(clk), .rst_n(rst_n), .srcClk(srcClk), .nOePin(nOePin),
    .linkMask(linkMask), .invert(invert), .parkMode(parkMode),
    .powerDown(powerDown), .clkOut(clkOut), .clkOe(clkOe)
  );

  // source i toggles every i+2 cycles; outputs are read after the falling edge
  task automatic tick();
    @(negedge clk);
    expSrc = hPrev;
    hPrev  = srcClk;
    for (int i = 0; i < 8; i++) begin
      cnt[i]++;
      if (cnt[i] == i + 2) begin
        cnt[i] = 0;
        srcClk[i] = ~srcClk[i];
      end
    end
  endtask

  // records output 3 (half period 5); the pins change after sample 20
  task automatic traceRuns(input string tag, input logic [2:0] newPins,
                           input int expFirst, input logic expLast, input bit lastLong);
    logic tr [80];
    int runLen, mids, badLen;
    bit firstRun, ok;
    for (int k = 0; k < 80; k++) begin
      tick();
      tr[k] = clkOut[3];
      if (k == 20) nOePin = newPins;
    end
    ok = 1'b1; runLen = 1; mids = 0; badLen = 5; firstRun = 1'b1;
    for (int k = 1; k < 80; k++) begin
      if (tr[k] == tr[k-1]) runLen++;
      else begin
        if (!firstRun) begin
          mids++;
          if (runLen != 5) begin ok = 1'b0; badLen = runLen; end
        end
        firstRun = 1'b0;
        runLen = 1;
      end
    end
    if (mids < 2) ok = 1'b0;
    if (expFirst >= 0 && tr[0] != expFirst[0]) ok = 1'b0;
    if (tr[79] != expLast) ok = 1'b0;
    if (lastLong && runLen < 20) ok = 1'b0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual first=%0b last=%0b lastRun=%0d fullRuns=%0d runLen=%0d, expected first=%0d last=%0b runLen=5",
               tag, tr[0], tr[79], runLen, mids, badLen, expFirst, expLast);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    repeat (4) tick();
    // R1: reset holds outputs low
    checks++;
    if (clkOut !== 8'h00 || clkOe !== 8'h00) begin
      fails++;
      $display("FAIL R1: actual out=%h oe=%h, expected out=00 oe=00", clkOut, clkOe);
    end
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [7:0] expRun, pdv, inv;
      logic [15:0] pk;
      logic [7:0] bad, actO, actE, expO, expE;
      nOePin    = VECS[v][42:40];
      pdv       = VECS[v][39:32];
      inv       = VECS[v][31:24];
      pk        = VECS[v][23:8];
      expRun    = VECS[v][7:0];
      powerDown = pdv; invert = inv; parkMode = pk;
      repeat (40) tick();
      bad = '0; actO = '0; actE = '0; expO = '0; expE = '0;
      repeat (40) begin
        tick();
        for (int i = 0; i < 8; i++) begin
          logic eo, ee;
          if (pdv[i])          begin eo = 1'b0; ee = 1'b0; end
          else if (expRun[i])  begin eo = expSrc[i] ^ inv[i]; ee = 1'b1; end
          else if (pk[2*i+1])  begin eo = 1'b0; ee = 1'b0; end
          else                 begin eo = pk[2*i]; ee = 1'b1; end
          if (!bad[i] && (clkOut[i] !== eo || clkOe[i] !== ee)) begin
            bad[i] = 1'b1;
            actO[i] = clkOut[i]; actE[i] = clkOe[i]; expO[i] = eo; expE[i] = ee;
          end
        end
      end
      for (int i = 0; i < 8; i++) begin
        checks++;
        if (bad[i]) begin
          fails++;
          $display("FAIL R2/R3/R4/R7/R8/R9 vector %0d output %0d: actual out=%b oe=%b, expected out=%b oe=%b",
                   v, i, actO[i], actE[i], expO[i], expE[i]);
        end
      end
    end

    // R5: enabling output 3 (pins 0 and 2) from a low park gives full pulses
    powerDown = '0; invert = '0; parkMode = 16'h0000;
    nOePin = 3'b111;
    repeat (40) tick();
    traceRuns("R5 enable start", 3'b000, 0, 1'b0, 1'b0);

    // R6: raising pin 0 stops output 3 after a full cycle, parked high
    parkMode = 16'h0040;
    nOePin = 3'b000;
    repeat (40) tick();
    traceRuns("R6 disable park high", 3'b001, -1, 1'b1, 1'b1);

    // R6 with R8: inverted output parks low after its last full high phase
    invert = 8'h08; parkMode = 16'h0000;
    nOePin = 3'b000;
    repeat (40) tick();
    traceRuns("R6 R8 disable inverted", 3'b100, -1, 1'b0, 1'b1);

    // R3: pin 2 alone still holds output 3 off while pin 0 is low
    invert = '0; parkMode = 16'h0040;
    nOePin = 3'b100;
    repeat (40) tick();
    checks++;
    if (clkOut[3] !== 1'b1 || clkOe[3] !== 1'b1) begin
      fails++;
      $display("FAIL R3: actual out=%b oe=%b, expected out=1 oe=1", clkOut[3], clkOe[3]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule